// File: doc/BRIEF.md
# Center-Aligned PWM Timer

A 16-bit timer that counts from zero up to a programmed modulo, then back down to zero, and repeats. The full period is therefore twice the modulo in clock cycles. Each compare channel compares its own value with the counter. It drives an output that is active for a window centred on count zero, with a width of twice the compare value. Because every channel's window is centred on the same point, the channel edges are spread across the period instead of all falling on one clock edge.

Software reaches the block over a byte-wide register port. The 16-bit modulo and compare values are written one byte at a time into holding buffers. A buffered pair moves to the live register only once both bytes are present. When the counter is stopped, this happens one cycle after the pair completes. When the counter runs, it happens on the step into the modulo count. A write to the timer control register drops any half-written modulo pair. A write to a channel control register does the same for that channel's value. A sticky flag with an optional interrupt marks each arrival at the modulo count.

Top module: `cpwm_timer`

## Requirements
- R1: While running, the counter steps +1 up to the limit, then -1 down to 0, then up again, giving a period of 2*limit cycles. The limit is the modulo, or 0xFFFF when the modulo is 0. After reset the count is 0 and counting up.
- R2: The clock-select field is control bits [1:0]. While it is 0, the counter and its direction hold their values.
- R3: With channel control bit1 (invert) at 0, the output is high from the down-count match (count equal to the value) until the up-count match, and low for the rest. This gives 2*value high cycles per period.
- R4: Channel control bit1 = 1 inverts the output. Channel control bit0 = 0 (disable) holds the output at 0.
- R5: A value of 0 keeps the output at its inactive level for the whole period. A value at or above the limit keeps it at the active level.
- R6: The flag (control bit7) is set on the step into the limit count. Writing 1 to bit7 clears it. irq_o is the flag ANDed with control bit6.
- R7: Value bytes are written high at offset 0 and low at offset +1 of a register pair, in either order. The live value is unchanged until both bytes are held. Reads return the live value.
- R8: With the clock stopped, a completed pair becomes live one cycle after its second byte.
- R9: With the clock running, a completed pair becomes live on the count step from limit-1 to limit, and not before.
- R10: A write to the control register (address 0) cancels a partial modulo pair. A write to a channel's control register cancels that channel's partial value pair.

Address map: 0 control, 1/2 count high/low, 3/4 modulo high/low. Channel n uses 5+3n for control and 6+3n/7+3n for its value high/low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pwm_o | output | NUM_CH | Channel outputs |
| irq_o | output | 1 | Flag interrupt request |

## Verification
A register write lands on the clock edge after it is driven. A stopped-clock pair load is visible one edge later, so the bench reads back two negative edges after the last byte. The flag rises on the same edge that brings the count to the limit, so the bench samples it at the negedge that follows and checks the count there too. Running-mode loads are checked by reading the old value straight after the pair completes, and the new one when the flag reappears. Pulse width and period are measured at negative edges over whole periods, starting from a freshly reset counter, so the expected counts 2*value and 2*limit hold regardless of phase.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W     = 16;
  localparam int A_CTRL    = 0;
  localparam int A_CNT_H   = 1;
  localparam int A_CNT_L   = 2;
  localparam int A_MOD_H   = 3;
  localparam int A_MOD_L   = 4;
  localparam int CH_BASE   = 5;
  localparam int CH_STRIDE = 3;
  localparam int B_IE      = 6;
  localparam int B_FLAG    = 7;
  localparam int B_EN      = 0;
  localparam int B_INV     = 1;

  // modulo 0 selects the full 16-bit range
  function automatic logic [CNT_W-1:0] cnt_limit(input logic [CNT_W-1:0] m);
    return (m == '0) ? '1 : m;
  endfunction
endpackage

// File: rtl/cpwm_dbuf.sv
module cpwm_dbuf (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_hi_i,
  input  logic        wr_lo_i,
  input  logic        cancel_i,
  input  logic [7:0]  wdata_i,
  input  logic        load_ok_i,
  output logic [15:0] val_o
);
  logic [7:0] hold_hi, hold_lo;
  logic       hi_seen, lo_seen;
  logic       load;

  assign load = hi_seen & lo_seen & load_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_hi <= '0;
      hold_lo <= '0;
      hi_seen <= 1'b0;
      lo_seen <= 1'b0;
      val_o   <= '0;
    end else begin
      if (wr_hi_i) hold_hi <= wdata_i;
      if (wr_lo_i) hold_lo <= wdata_i;
      if (cancel_i) begin
        hi_seen <= 1'b0;
        lo_seen <= 1'b0;
      end else begin
        if (wr_hi_i)   hi_seen <= 1'b1;
        else if (load) hi_seen <= 1'b0;
        if (wr_lo_i)   lo_seen <= 1'b1;
        else if (load) lo_seen <= 1'b0;
      end
      if (load) val_o <= {hold_hi, hold_lo};
    end
  end

  assert_partial_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_seen && lo_seen) |=> $stable(val_o));
  assert_wait_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ok_i |=> $stable(val_o));
  assert_cancel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && !wr_hi_i && !wr_lo_i) |=> (!hi_seen && !lo_seen));
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter import cpwm_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             top_step_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  assign limit_o = cnt_limit(mod_i);
  // step into the limit: from limit-1 going up, or 0 -> 1 turnaround when limit is 1
  assign top_step_o = run_i && (cnt_q == limit_o - 1'b1) && (up_q || cnt_q == '0);
  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (run_i) begin
      if (up_q) begin
        if (cnt_q >= limit_o) begin
          up_q  <= 1'b0;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        up_q  <= 1'b1;
        cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ($stable(cnt_q) && $stable(up_q)));
  assert_down_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !up_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_turn_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && up_q && cnt_q >= limit_o) |=> !up_q);
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel import cpwm_pkg::*; (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             en_i,
  input  logic             inv_i,
  output logic             pwm_o
);
  logic active;

  // up-count match ends the window, down-count match starts it
  always_comb begin
    if (val_i == '0)            active = 1'b0;
    else if (val_i >= limit_i)  active = 1'b1;
    else if (up_i)              active = cnt_i < val_i;
    else                        active = cnt_i <= val_i;
  end

  assign pwm_o = en_i & (active ^ inv_i);
endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer import cpwm_pkg::*; #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              irq_o
);
  localparam int LAST_ADDR = CH_BASE + CH_STRIDE * NUM_CH - 1;
  localparam int ADDR_SPAN = 1 << ADDR_W;

  logic [1:0]       clk_sel_q;
  logic             ie_q, flag_q;
  logic             run, wr_ctrl, top_step, load_ok;
  logic [CNT_W-1:0] cnt, limit, mod_val;
  logic             up;
  logic [CNT_W-1:0] ch_val [NUM_CH];
  logic [NUM_CH-1:0] ch_en, ch_inv;

  assign run     = clk_sel_q != 2'd0;
  assign load_ok = !run || top_step;
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign irq_o   = flag_q & ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sel_q <= '0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        clk_sel_q <= wdata_i[1:0];
        ie_q      <= wdata_i[B_IE];
      end
      if (top_step)                     flag_q <= 1'b1;
      else if (wr_ctrl && wdata_i[B_FLAG]) flag_q <= 1'b0;
    end
  end

  cpwm_counter u_cnt (
    .clk_i, .rst_ni, .run_i(run), .mod_i(mod_val),
    .cnt_o(cnt), .up_o(up), .limit_o(limit), .top_step_o(top_step)
  );

  cpwm_dbuf u_mod (
    .clk_i, .rst_ni,
    .wr_hi_i(wr_en_i && addr_i == ADDR_W'(A_MOD_H)),
    .wr_lo_i(wr_en_i && addr_i == ADDR_W'(A_MOD_L)),
    .cancel_i(wr_ctrl), .wdata_i, .load_ok_i(load_ok), .val_o(mod_val)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * g;
    logic wr_cc;
    assign wr_cc = wr_en_i && (addr_i == ADDR_W'(BASE));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_en[g]  <= 1'b0;
        ch_inv[g] <= 1'b0;
      end else if (wr_cc) begin
        ch_en[g]  <= wdata_i[B_EN];
        ch_inv[g] <= wdata_i[B_INV];
      end
    end

    cpwm_dbuf u_val (
      .clk_i, .rst_ni,
      .wr_hi_i(wr_en_i && addr_i == ADDR_W'(BASE + 1)),
      .wr_lo_i(wr_en_i && addr_i == ADDR_W'(BASE + 2)),
      .cancel_i(wr_cc), .wdata_i, .load_ok_i(load_ok), .val_o(ch_val[g])
    );

    cpwm_channel u_out (
      .cnt_i(cnt), .up_i(up), .limit_i(limit), .val_i(ch_val[g]),
      .en_i(ch_en[g]), .inv_i(ch_inv[g]), .pwm_o(pwm_o[g])
    );

    assert_zero_val_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[g] && !ch_inv[g] && ch_val[g] == '0) |-> !pwm_o[g]);
  end

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      A_CTRL:  rdata_o = {flag_q, ie_q, 4'b0, clk_sel_q};
      A_CNT_H: rdata_o = cnt[15:8];
      A_CNT_L: rdata_o = cnt[7:0];
      A_MOD_H: rdata_o = mod_val[15:8];
      A_MOD_L: rdata_o = mod_val[7:0];
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (int'(addr_i) == CH_BASE + CH_STRIDE * c)
            rdata_o = {6'b0, ch_inv[c], ch_en[c]};
          else if (int'(addr_i) == CH_BASE + CH_STRIDE * c + 1)
            rdata_o = ch_val[c][15:8];
          else if (int'(addr_i) == CH_BASE + CH_STRIDE * c + 2)
            rdata_o = ch_val[c][7:0];
        end
      end
    endcase
  end

  initial begin
    assert_map_fits: assert (LAST_ADDR < ADDR_SPAN);
  end

  assert_flag_on_up_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/sim_cpwm_timer.sv
module sim_cpwm_timer;
  localparam int NCH = 2;
  localparam int A_CTRL = 0, A_CNT = 1, A_MOD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NCH-1:0] pwm;
  logic irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cpwm_timer #(.NUM_CH(NCH), .ADDR_W(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  function automatic int ch_ctl(int c); return 5 + 3 * c; endfunction

  function automatic int exp_high(int m, int v, bit inv, bit en);
    int b;
    b = (v == 0) ? 0 : (v >= m) ? 2 * m : 2 * v;
    if (inv) b = 2 * m - b;
    return en ? b : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr16(int a, int v); wr(a, v >> 8); wr(a + 1, v & 255); endtask

  task automatic rd(int a, output int d); addr = 5'(a); #1; d = int'(rdata); endtask

  task automatic rd16(int a, output int v);
    int h, l;
    rd(a, h); rd(a + 1, l); v = (h << 8) | l;
  endtask

  task automatic do_reset();
    @(negedge clk); we = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic measure(int c, int n, output int hi_c, output int hi_o);
    hi_c = 0; hi_o = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi_c += int'(pwm[c]);
      hi_o += int'(pwm[1 - c]);
    end
  endtask

  task automatic rise_gap(int c, int lim, output int gap);
    int first = -1;
    bit prev = pwm[c];
    gap = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (!prev && pwm[c]) begin
        if (first < 0) first = i;
        else begin gap = i - first; break; end
      end
      prev = pwm[c];
    end
  endtask

  task automatic trial(int c, int m, int v, bit inv, bit en, string req);
    int hc, ho, gap;
    do_reset();
    wr16(A_MOD, m);
    wr(ch_ctl(c), {6'b0, inv, en});
    wr16(ch_ctl(c) + 1, v);
    wr(A_CTRL, 1);
    measure(c, 2 * m, hc, ho);
    chk(req, hc, exp_high(m, v, inv, en));
    chk("R4 idle channel low", ho, 0);
    if (en && v > 0 && v < m) begin
      rise_gap(c, 8 * m + 8, gap);
      chk("R1 period", gap, 2 * m);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d, v, gap;
    bit hit;
    void'($urandom(32'd7331));
    do_reset();

    // reset state
    rd(A_CTRL, d);  chk("R6 reset ctrl", d, 0);
    rd16(A_CNT, v); chk("R1 reset count", v, 0);
    rd16(A_MOD, v); chk("R7 reset modulo", v, 0);
    chk("R4 reset outputs", int'(pwm), 0);
    chk("R6 reset irq", int'(irq), 0);

    // stopped-clock loads, both byte orders
    wr(A_MOD, 8'h12); idle(2);
    rd16(A_MOD, v); chk("R7 half pair not live", v, 0);
    wr(A_MOD + 1, 8'h34); idle(1);
    rd16(A_MOD, v); chk("R8 stopped load", v, 16'h1234);
    wr(ch_ctl(0) + 2, 8'h05); idle(2);
    rd16(ch_ctl(0) + 1, v); chk("R7 low byte first not live", v, 0);
    wr(ch_ctl(0) + 1, 8'h00); idle(1);
    rd16(ch_ctl(0) + 1, v); chk("R8 low-first pair load", v, 5);

    // cancel of half pairs
    wr(A_MOD, 8'h00); wr(A_CTRL, 0); wr(A_MOD + 1, 8'h10); idle(2);
    rd16(A_MOD, v); chk("R10 modulo pair cancelled", v, 16'h1234);
    wr(ch_ctl(0) + 1, 8'h01); wr(ch_ctl(0), 0); wr(ch_ctl(0) + 2, 8'h00); idle(2);
    rd16(ch_ctl(0) + 1, v); chk("R10 channel pair cancelled", v, 5);

    // stopped counter holds
    idle(5);
    rd16(A_CNT, v); chk("R2 stopped count holds", v, 0);

    // flag and interrupt
    do_reset();
    wr16(A_MOD, 4);
    wr(A_CTRL, 8'h41);
    idle(3);
    rd(A_CTRL, d); chk("R6 flag not yet", d >> 7, 0);
    idle(1);
    rd(A_CTRL, d); chk("R6 flag at limit", d >> 7, 1);
    rd16(A_CNT, v); chk("R1 count at limit", v, 4);
    chk("R6 irq enabled", int'(irq), 1);
    wr(A_CTRL, 8'hC1);
    rd(A_CTRL, d); chk("R6 write-one clear", d >> 7, 0);
    chk("R6 irq after clear", int'(irq), 0);
    wr(A_CTRL, 8'h01); idle(6);
    rd(A_CTRL, d); chk("R6 flag sets again", d >> 7, 1);
    chk("R6 irq masked", int'(irq), 0);
    wr(A_CTRL, 0); idle(3);
    rd16(A_CNT, d); idle(4); rd16(A_CNT, v);
    chk("R2 count frozen after stop", v, d);

    // running load waits for the step into the limit
    do_reset();
    wr16(A_MOD, 20);
    wr(ch_ctl(0), 1);
    wr16(ch_ctl(0) + 1, 2);
    wr(A_CTRL, 1);
    rise_gap(0, 100, gap);
    wr(A_CTRL, 8'h81);
    wr16(A_MOD, 30);
    rd16(A_MOD, v); chk("R9 not live mid-period", v, 20);
    hit = 1'b0;
    for (int i = 0; i < 80 && !hit; i++) begin
      @(negedge clk);
      rd(A_CTRL, d);
      hit = d[7];
    end
    chk("R6 flag seen", int'(hit), 1);
    rd16(A_MOD, v); chk("R9 live at limit step", v, 30);
    rd16(A_CNT, v); chk("R9 step reached old limit", v, 20);
    rise_gap(0, 200, gap);
    chk("R1 period after reload", gap, 60);

    // directed corners
    trial(0, 10, 0, 1'b0, 1'b1, "R5 zero value");
    trial(1, 10, 10, 1'b0, 1'b1, "R5 value equals limit");
    trial(0, 6, 9, 1'b0, 1'b1, "R5 value above limit");
    trial(1, 12, 5, 1'b1, 1'b1, "R4 inverted width");
    trial(0, 12, 5, 1'b0, 1'b0, "R4 disabled low");
    trial(0, 9, 1, 1'b0, 1'b1, "R3 single step width");

    // random
    for (int t = 0; t < 14; t++) begin
      int m, val, c;
      bit inv, en;
      m   = int'($urandom_range(40, 2));
      val = int'($urandom_range(m + 3, 0));
      c   = int'($urandom_range(1, 0));
      inv = 1'($urandom_range(1, 0));
      en  = ($urandom_range(7, 0) != 0);
      trial(c, m, val, inv, en, "R3 random width");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule